// File: doc/BRIEF.md
# Page-Mode DRAM Sequencer

This block turns single-word requests from a synchronous client into the strobe sequences that an asynchronous DRAM with multiplexed address pins expects. A request carries an address, a read/write flag and write data, and it is taken with a valid/ready handshake. The block splits the address into a row half and a column half. It places the row on the shared address pins before the row strobe falls and the column before the column strobe falls. It drives the active-low row, column, write and output-enable strobes, and it owns the direction control of the shared data pins.

After an access the row is left open. A later request to the same row needs only a new column strobe cycle. A request to another row first closes the open row, waits out the precharge time, and then opens the new row. Every minimum interval between strobe edges is a parameter counted in clock cycles. A built-in scheduler splits the refresh period over all rows and runs one row-only refresh cycle per slot. A refresh that is due takes priority over client requests.

Top module: `dram_page_ctrl`

## Requirements
- R1: While reset is held and in the first idle cycle after it, `ras_no`, `cas_no`, `we_no` and `oe_no` are high (1 = inactive), `dq_oe_o` and `rd_valid_o` are 0, and `req_ready_o` is 1.
- R2: The request address is {row, column}, with the row in the upper ROW_W bits and the column in the lower ROW_W bits. `dram_addr_o` holds the row when `ras_no` falls and the column when `cas_no` falls.
- R3: `we_no` and `oe_no` are never low together. For a write, `we_no` is low and `oe_no` high, and `dq_oe_o` drives the request data. `we_no` is already low before `cas_no` falls. For a read, `we_no` is high and `oe_no` low.
- R4: A read returns the word at its address on `rd_data_o`. `rd_valid_o` is high for exactly one cycle, T_CAC cycles after the clock edge at which `cas_no` fell.
- R5: Two falls of `ras_no` are at least T_RC cycles apart, and `ras_no` stays high for at least T_RP cycles before each fall.
- R6: `cas_no` falls only while `ras_no` is low. Two falls of `cas_no` are at least T_PC cycles apart, and a fall of `cas_no` comes at least T_RAC−T_CAC cycles after a fall of `ras_no`, so read data arrives no earlier than T_RAC cycles after `ras_no` fell.
- R7: Requests to the row already open are served with column cycles only. `ras_no` stays low and does not fall again between them.
- R8: A request to a row other than the open one raises `ras_no`, then lowers it again with the new row on `dram_addr_o`.
- R9: Every (REF_PERIOD >> ROW_W) cycles one refresh runs: `ras_no` falls with a refresh row on `dram_addr_o` and rises again with no fall of `cas_no` in between. The refresh rows step upward by one starting at 0 and wrap after the last row.
- R10: While a refresh is due, `req_ready_o` is 0. An open row is closed and precharged before the refresh, and requests held across the refresh complete with correct data.
- R11: A request is taken only on a cycle with `req_valid_i` and `req_ready_o` both high. `req_ready_o` drops in the cycle after a request is taken, and each read request gives exactly one `rd_valid_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be taken this cycle |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 2*ROW_W | Word address, row in the upper half |
| req_wdata_i | input | DATA_W | Write data |
| rd_valid_o | output | 1 | One-cycle pulse with read data |
| rd_data_o | output | DATA_W | Read data |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write enable, active low |
| oe_no | output | 1 | Output enable, active low |
| dram_addr_o | output | ROW_W | Multiplexed row/column address |
| dq_o | output | DATA_W | Data toward the memory |
| dq_oe_o | output | 1 | 1 = block drives the data pins |
| dq_i | input | DATA_W | Data from the memory |

## Verification
A due refresh and a pending client request can arrive in the same cycle while a row is open. The bench provokes this by holding a continuous stream of reads to one row across a refresh slot. It then judges the outcome three ways. Exactly one refresh must occur, and it must be a row-only cycle with the next row in sequence. The client row must be reopened exactly once after it. Every read in the stream must still return the expected word. Strobe-interval monitors run during this stream, so the closing and precharge before the refresh are timed as well.

// File: rtl/dram_pkg.sv
package dram_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_ROW, S_RCD, S_COL, S_CAS, S_OPEN, S_CLOSE, S_REF
  } seq_state_e;

  localparam int TM_RC  = 0;
  localparam int TM_RP  = 1;
  localparam int TM_RAS = 2;
  localparam int TM_RCD = 3;
  localparam int TM_PC  = 4;
  localparam int TM_CAC = 5;
  localparam int TM_N   = 6;
endpackage

// File: rtl/dram_timer.sv
module dram_timer #(
  parameter int LIMIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic ok_o
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (start_i)     cnt_q <= CW'(LIMIT - 1);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  // next edge may fire LIMIT cycles after start
  assign ok_o = (cnt_q == '0);
endmodule

// File: rtl/dram_ref_sched.sv
module dram_ref_sched #(
  parameter int INTERVAL = 3906,
  parameter int ROW_W    = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ack_i,
  output logic             pend_o,
  output logic [ROW_W-1:0] row_o
);
  localparam int CW = $clog2(INTERVAL);
  logic [CW-1:0] cnt_q;
  logic          tick;

  assign tick = (cnt_q == CW'(INTERVAL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_o <= 1'b0;
      row_o  <= '0;
    end else begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
      if (tick)       pend_o <= 1'b1;
      else if (ack_i) pend_o <= 1'b0;
      if (ack_i) row_o <= row_o + 1'b1;
    end
  end
endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_pkg::*;
#(
  parameter int ROW_W  = 9,
  parameter int DATA_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic                req_we_i,
  input  logic [2*ROW_W-1:0]  req_addr_i,
  input  logic [DATA_W-1:0]   req_wdata_i,
  output logic                req_ready_o,
  input  logic                ref_pend_i,
  input  logic [ROW_W-1:0]    ref_row_i,
  output logic                ref_ack_o,
  input  logic [TM_N-1:0]     tm_ok_i,
  output logic                ras_fall_o,
  output logic                ras_rise_o,
  output logic                cas_fall_o,
  output logic                ras_no,
  output logic                cas_no,
  output logic                we_no,
  output logic                oe_no,
  output logic [ROW_W-1:0]    addr_o,
  output logic [DATA_W-1:0]   dq_o,
  output logic                dq_oe_o,
  input  logic [DATA_W-1:0]   dq_i,
  output logic                rd_valid_o,
  output logic [DATA_W-1:0]   rd_data_o
);
  seq_state_e        st_q, st_d;
  logic              ras_d, cas_d, we_d, oe_d, den_d, rdv_d, isref_q, isref_d, wr_q, wr_d;
  logic [ROW_W-1:0]  addr_d, row_q, row_d, col_q, col_d, open_q, open_d;
  logic [DATA_W-1:0] wdat_d, rdat_d;
  logic [ROW_W-1:0]  req_row, req_col;

  assign req_row     = req_addr_i[2*ROW_W-1:ROW_W];
  assign req_col     = req_addr_i[ROW_W-1:0];
  assign req_ready_o = !ref_pend_i && (st_q == S_IDLE || st_q == S_OPEN);

  always_comb begin
    st_d = st_q;   ras_d = ras_no; cas_d = cas_no; we_d = we_no; oe_d = oe_no;
    den_d = dq_oe_o; addr_d = addr_o; row_d = row_q; col_d = col_q; wr_d = wr_q;
    wdat_d = dq_o; open_d = open_q; isref_d = isref_q; rdat_d = rd_data_o;
    rdv_d = 1'b0;  ref_ack_o = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (ref_pend_i) begin
          isref_d = 1'b1; addr_d = ref_row_i; st_d = S_ROW;
        end else if (req_valid_i) begin
          row_d = req_row; col_d = req_col; wr_d = req_we_i; wdat_d = req_wdata_i;
          addr_d = req_row; st_d = S_ROW;
        end
      end
      S_ROW: begin
        if (tm_ok_i[TM_RP] && tm_ok_i[TM_RC]) begin
          ras_d = 1'b0;
          if (isref_q) st_d = S_REF;
          else begin open_d = addr_o; st_d = S_RCD; end
        end
      end
      S_REF: begin
        if (tm_ok_i[TM_RAS]) begin
          ras_d = 1'b1; ref_ack_o = 1'b1; isref_d = 1'b0; st_d = S_IDLE;
        end
      end
      S_RCD: begin
        if (tm_ok_i[TM_RCD]) begin
          addr_d = col_q; we_d = ~wr_q; oe_d = wr_q; den_d = wr_q; st_d = S_COL;
        end
      end
      S_COL: begin
        if (tm_ok_i[TM_PC]) begin cas_d = 1'b0; st_d = S_CAS; end
      end
      S_CAS: begin
        if (tm_ok_i[TM_CAC]) begin
          cas_d = 1'b1; we_d = 1'b1; oe_d = 1'b1; den_d = 1'b0;
          rdv_d = ~wr_q;
          if (!wr_q) rdat_d = dq_i;
          st_d = S_OPEN;
        end
      end
      S_OPEN: begin
        if (ref_pend_i) begin
          isref_d = 1'b1; st_d = S_CLOSE;
        end else if (req_valid_i) begin
          row_d = req_row; col_d = req_col; wr_d = req_we_i; wdat_d = req_wdata_i;
          if (req_row == open_q) begin
            addr_d = req_col; we_d = ~req_we_i; oe_d = req_we_i; den_d = req_we_i;
            st_d = S_COL;
          end else begin
            st_d = S_CLOSE;
          end
        end
      end
      S_CLOSE: begin
        if (tm_ok_i[TM_RAS]) begin
          ras_d = 1'b1; addr_d = isref_q ? ref_row_i : row_q; st_d = S_ROW;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  assign ras_fall_o = ras_no & ~ras_d;
  assign ras_rise_o = ~ras_no & ras_d;
  assign cas_fall_o = cas_no & ~cas_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; ras_no <= 1'b1; cas_no <= 1'b1; we_no <= 1'b1; oe_no <= 1'b1;
      dq_oe_o <= 1'b0; addr_o <= '0; row_q <= '0; col_q <= '0; wr_q <= 1'b0;
      dq_o <= '0; open_q <= '0; isref_q <= 1'b0; rd_valid_o <= 1'b0; rd_data_o <= '0;
    end else begin
      st_q <= st_d; ras_no <= ras_d; cas_no <= cas_d; we_no <= we_d; oe_no <= oe_d;
      dq_oe_o <= den_d; addr_o <= addr_d; row_q <= row_d; col_q <= col_d; wr_q <= wr_d;
      dq_o <= wdat_d; open_q <= open_d; isref_q <= isref_d; rd_valid_o <= rdv_d;
      rd_data_o <= rdat_d;
    end
  end
endmodule

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl
  import dram_pkg::*;
#(
  parameter int ROW_W      = 9,
  parameter int DATA_W     = 8,
  parameter int T_RAC      = 15,
  parameter int T_RC       = 28,
  parameter int T_CAC      = 4,
  parameter int T_PC       = 9,
  parameter int T_RP       = 10,
  parameter int REF_PERIOD = 2000000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic                req_we_i,
  input  logic [2*ROW_W-1:0]  req_addr_i,
  input  logic [DATA_W-1:0]   req_wdata_i,
  output logic                rd_valid_o,
  output logic [DATA_W-1:0]   rd_data_o,
  output logic                ras_no,
  output logic                cas_no,
  output logic                we_no,
  output logic                oe_no,
  output logic [ROW_W-1:0]    dram_addr_o,
  output logic [DATA_W-1:0]   dq_o,
  output logic                dq_oe_o,
  input  logic [DATA_W-1:0]   dq_i
);
  localparam int T_RCD   = T_RAC - T_CAC;
  localparam int T_RAS   = T_RC - T_RP;
  localparam int REF_INT = REF_PERIOD >> ROW_W;
  localparam int TM_LIM [TM_N] = '{T_RC, T_RP, T_RAS, T_RCD, T_PC, T_CAC};

  logic [TM_N-1:0]  tm_start, tm_ok;
  logic             ras_fall, ras_rise, cas_fall, ref_pend, ref_ack;
  logic [ROW_W-1:0] ref_row;

  assign tm_start[TM_RC]  = ras_fall;
  assign tm_start[TM_RAS] = ras_fall;
  assign tm_start[TM_RCD] = ras_fall;
  assign tm_start[TM_RP]  = ras_rise;
  assign tm_start[TM_PC]  = cas_fall;
  assign tm_start[TM_CAC] = cas_fall;

  for (genvar gi = 0; gi < TM_N; gi++) begin : g_tm
    dram_timer #(.LIMIT(TM_LIM[gi])) u_tm (
      .clk_i, .rst_ni, .start_i(tm_start[gi]), .ok_o(tm_ok[gi])
    );
  end

  dram_ref_sched #(.INTERVAL(REF_INT), .ROW_W(ROW_W)) u_ref (
    .clk_i, .rst_ni, .ack_i(ref_ack), .pend_o(ref_pend), .row_o(ref_row)
  );

  dram_seq #(.ROW_W(ROW_W), .DATA_W(DATA_W)) u_seq (
    .clk_i, .rst_ni, .req_valid_i, .req_we_i, .req_addr_i, .req_wdata_i, .req_ready_o,
    .ref_pend_i(ref_pend), .ref_row_i(ref_row), .ref_ack_o(ref_ack), .tm_ok_i(tm_ok),
    .ras_fall_o(ras_fall), .ras_rise_o(ras_rise), .cas_fall_o(cas_fall),
    .ras_no, .cas_no, .we_no, .oe_no, .addr_o(dram_addr_o), .dq_o, .dq_oe_o, .dq_i,
    .rd_valid_o, .rd_data_o
  );
endmodule

// File: rtl/dram_page_ctrl_chk.sv
module dram_page_ctrl_chk #(
  parameter int T_RAC = 15,
  parameter int T_RC  = 28,
  parameter int T_CAC = 4,
  parameter int T_PC  = 9,
  parameter int T_RP  = 10
) (
  input logic clk_i,
  input logic rst_ni,
  input logic ras_no,
  input logic cas_no,
  input logic we_no,
  input logic oe_no,
  input logic dq_oe_o,
  input logic rd_valid_o
);
  localparam int T_RCD = T_RAC - T_CAC;
  logic [15:0] since_ras_fall, since_ras_rise, since_cas_fall;
  logic        ras_q, cas_q;

  function automatic logic [15:0] sat_inc(input logic [15:0] v);
    return (v == 16'hFFFF) ? v : v + 16'd1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ras_q <= 1'b1; cas_q <= 1'b1;
      since_ras_fall <= 16'hFFFF; since_ras_rise <= 16'hFFFF; since_cas_fall <= 16'hFFFF;
    end else begin
      ras_q <= ras_no; cas_q <= cas_no;
      since_ras_fall <= (ras_q && !ras_no) ? 16'd1 : sat_inc(since_ras_fall);
      since_ras_rise <= (!ras_q && ras_no) ? 16'd1 : sat_inc(since_ras_rise);
      since_cas_fall <= (cas_q && !cas_no) ? 16'd1 : sat_inc(since_cas_fall);
    end
  end

  p_we_oe_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!we_no && !oe_no));
  p_dq_dir_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> (!we_no && oe_no));
  p_early_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cas_no) |-> ($stable(we_no) && $stable(oe_no)));
  p_rd_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o);
  p_trc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_no) |-> since_ras_fall >= 16'(T_RC));
  p_trp_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_no) |-> since_ras_rise >= 16'(T_RP));
  p_cas_in_row_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cas_no |-> !ras_no);
  p_tpc_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cas_no) |-> since_cas_fall >= 16'(T_PC));
  p_trcd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cas_no) |-> since_ras_fall >= 16'(T_RCD));
endmodule

bind dram_page_ctrl dram_page_ctrl_chk #(
  .T_RAC(T_RAC), .T_RC(T_RC), .T_CAC(T_CAC), .T_PC(T_PC), .T_RP(T_RP)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ras_no(ras_no), .cas_no(cas_no), .we_no(we_no),
  .oe_no(oe_no), .dq_oe_o(dq_oe_o), .rd_valid_o(rd_valid_o)
);

// File: tb/sim_dram_page_ctrl.sv
`timescale 1ns/1ps
module sim_dram_page_ctrl;
  localparam int ROW_W = 4, DATA_W = 8, AW = 2*ROW_W;
  localparam int T_RAC = 15, T_RC = 28, T_CAC = 4, T_PC = 9, T_RP = 10;
  localparam int REF_PERIOD = 6400, REF_INT = REF_PERIOD >> ROW_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic vld = 1'b0, wr = 1'b0;
  logic [AW-1:0] adr = '0;
  logic [DATA_W-1:0] wd = '0;
  logic req_ready_o, rd_valid_o, ras_no, cas_no, we_no, oe_no, dq_oe_o;
  logic [DATA_W-1:0] rd_data_o, dq_o, dq_i;
  logic [ROW_W-1:0] dram_addr_o;

  logic [DATA_W-1:0] mem [1<<AW];
  logic [DATA_W-1:0] exp_mem [1<<AW];
  logic [ROW_W-1:0] row_l = '0, col_l = '0, exp_ref = '0;
  int cyc = 0, last_ras_fall = -1000, last_ras_rise = -1000, last_cas_fall = -1000;
  int last_ref_fall = -1, ras_falls = 0, ref_cnt = 0, checks = 0, fails = 0, rd_cyc = 0;
  bit cas_seen = 0, wrapped = 0, done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  dram_page_ctrl #(.ROW_W(ROW_W), .DATA_W(DATA_W), .T_RAC(T_RAC), .T_RC(T_RC),
    .T_CAC(T_CAC), .T_PC(T_PC), .T_RP(T_RP), .REF_PERIOD(REF_PERIOD)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(vld), .req_ready_o, .req_we_i(wr),
    .req_addr_i(adr), .req_wdata_i(wd), .rd_valid_o, .rd_data_o, .ras_no, .cas_no,
    .we_no, .oe_no, .dram_addr_o, .dq_o, .dq_oe_o, .dq_i);

  assign dq_i = (!cas_no && !oe_no) ? mem[{row_l, col_l}] : '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s: actual %0h expected %0h", tag, act, exp); end
  endtask

  // memory model and strobe monitors
  always @(negedge ras_no) if (rst_n === 1'b1) begin
    chk(cyc - last_ras_fall >= T_RC, "R5 row cycle", cyc - last_ras_fall, T_RC);
    chk(cyc - last_ras_rise >= T_RP, "R5 precharge", cyc - last_ras_rise, T_RP);
    last_ras_fall = cyc; row_l = dram_addr_o; cas_seen = 0; ras_falls++;
  end

  always @(posedge ras_no) if (rst_n === 1'b1) begin
    last_ras_rise = cyc;
    if (!cas_seen) begin
      chk(row_l == exp_ref, "R9 refresh row", row_l, exp_ref);
      if (last_ref_fall >= 0)
        chk((last_ras_fall - last_ref_fall > REF_INT - 100) &&
            (last_ras_fall - last_ref_fall < REF_INT + 100),
            "R9 refresh spacing", last_ras_fall - last_ref_fall, REF_INT);
      if (row_l == '1) wrapped = 1;
      exp_ref = row_l + 1'b1; last_ref_fall = last_ras_fall; ref_cnt++;
    end
  end

  always @(negedge cas_no) if (rst_n === 1'b1) begin
    cas_seen = 1;
    chk(!ras_no, "R6 column under open row", ras_no, 0);
    chk(cyc - last_cas_fall >= T_PC, "R6 column cycle", cyc - last_cas_fall, T_PC);
    chk(cyc - last_ras_fall >= T_RAC - T_CAC, "R6 row to column", cyc - last_ras_fall,
        T_RAC - T_CAC);
    col_l = dram_addr_o; last_cas_fall = cyc;
    if (!we_no) begin
      chk(oe_no && dq_oe_o, "R3 write strobes", {oe_no, dq_oe_o}, 3);
      mem[{row_l, col_l}] = dq_o;
    end else begin
      chk(!oe_no && !dq_oe_o, "R3 read strobes", {oe_no, dq_oe_o}, 0);
    end
  end

  always @(negedge clk) if (rst_n && !we_no && !oe_no)
    chk(0, "R3 we/oe overlap", 0, 1);

  task automatic issue(input bit we, input logic [AW-1:0] a, input logic [DATA_W-1:0] d);
    int n;
    @(negedge clk); vld = 1; wr = we; adr = a; wd = d;
    n = 0; while (!req_ready_o && n < 2000) begin @(negedge clk); n++; end
    @(negedge clk); vld = 0;
    if (we) exp_mem[a] = d;
    n = 0;
    if (!we) begin
      while (!rd_valid_o && n < 400) begin @(negedge clk); n++; end
      rd_cyc = cyc;
      chk(rd_valid_o, "R4 read valid", rd_valid_o, 1);
      chk(rd_data_o == exp_mem[a], "R4 read data", rd_data_o, exp_mem[a]);
      chk(cyc - last_cas_fall == T_CAC, "R4 data latency", cyc - last_cas_fall, T_CAC);
    end else begin
      while (!req_ready_o && n < 400) begin @(negedge clk); n++; end
      chk(mem[a] == d, "R2 write lands at row/column", mem[a], d);
    end
    chk({row_l, col_l} == a, "R2 address split", {row_l, col_l}, a);
  endtask

  task automatic wait_ref();
    int r0 = ref_cnt, n = 0;
    while (ref_cnt == r0 && n < 2000) begin @(negedge clk); n++; end
    chk(ref_cnt != r0, "R9 refresh occurs", ref_cnt, r0 + 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(ras_no && cas_no && we_no && oe_no, "R1 strobes in reset", {ras_no, cas_no, we_no, oe_no}, 4'hF);
    chk(!dq_oe_o && !rd_valid_o, "R1 outputs in reset", {dq_oe_o, rd_valid_o}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(ras_no && cas_no && we_no && oe_no, "R1 strobes after reset", {ras_no, cas_no, we_no, oe_no}, 4'hF);
    chk(req_ready_o, "R1 ready after reset", req_ready_o, 1);
  endtask

  task automatic t_basic();
    wait_ref();
    issue(1, 8'h12, 8'h3C);
    issue(0, 8'h12, 8'h00);
    issue(0, 8'h27, 8'h00);
  endtask

  task automatic t_page_and_miss();
    int f0;
    wait_ref();
    issue(1, 8'h51, 8'hA1);
    f0 = ras_falls;
    issue(0, 8'h51, 8'h00);
    issue(1, 8'h57, 8'hB7);
    issue(0, 8'h57, 8'h00);
    chk(ras_falls == f0, "R7 no new row open on hits", ras_falls - f0, 0);
    chk(!ras_no, "R7 row stays open", ras_no, 0);
    issue(0, 8'h93, 8'h00);
    chk(ras_falls == f0 + 1, "R8 miss reopens once", ras_falls - f0, 1);
    chk(row_l == 4'h9, "R8 new row latched", row_l, 9);
    chk(rd_cyc - last_ras_fall >= T_RAC, "R6 row access time", rd_cyc - last_ras_fall, T_RAC);
  endtask

  task automatic t_handshake();
    int n, pulses = 0;
    wait_ref();
    @(negedge clk); vld = 1; wr = 0; adr = 8'hC4;
    n = 0; while (!req_ready_o && n < 2000) begin @(negedge clk); n++; end
    @(negedge clk); vld = 0;
    chk(!req_ready_o, "R11 ready drops after accept", req_ready_o, 0);
    for (int i = 0; i < 120; i++) begin @(negedge clk); if (rd_valid_o) pulses++; end
    chk(pulses == 1, "R11 one response per read", pulses, 1);
  endtask

  task automatic t_collide();
    int f0, r0, extra = 0;
    wait_ref();
    f0 = ras_falls; r0 = ref_cnt;
    for (int i = 0; i < 120 && extra < 2; i++) begin
      issue(0, {4'h3, 4'(i)}, 8'h00);
      if (ref_cnt != r0) extra++;
    end
    chk(ref_cnt == r0 + 1, "R10 one refresh inside stream", ref_cnt - r0, 1);
    chk((ras_falls - f0) - (ref_cnt - r0) == 2, "R10 row closed and reopened",
        (ras_falls - f0) - (ref_cnt - r0), 2);
  endtask

  task automatic t_refresh_wrap();
    int n = 0;
    while (!wrapped && n < 30) begin wait_ref(); n++; end
    chk(wrapped, "R9 refresh rows wrap", wrapped, 1);
    wait_ref();
    chk(ref_cnt > (1 << ROW_W), "R9 all rows refreshed", ref_cnt, (1 << ROW_W) + 1);
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) begin
      mem[i] = DATA_W'(i) ^ 8'h5A; exp_mem[i] = DATA_W'(i) ^ 8'h5A;
    end
    t_reset();
    t_basic();
    t_page_and_miss();
    t_handshake();
    t_collide();
    t_refresh_wrap();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule